// File: doc/BRIEF.md
# Prescaled Baud Rate Generator

This block turns a fast reference clock into a one-cycle enable pulse at sixteen times the serial bit rate. A 16-bit divisor, presented as a low byte and a high byte, is captured when a load strobe is high. A counter then emits one pulse for every `divisor` timing steps. A timing step is either every reference cycle, or, when the prescale select is 1, every fourth reference cycle. The divide-by-four stage sits in front of the divisor counter.

The output is an enable that lasts one reference cycle and is not a derived clock. The serial shifters downstream stay in the reference clock domain and use the pulse as a clock enable. Writing a divisor restarts the count, so the new rate takes effect at once. A divisor of zero stops the pulses.

Top module: `baud_gen_top`

## Requirements
- R1: After a synchronous reset, `tick` is low and the latched divisor is zero. No pulse appears until a nonzero divisor is loaded.
- R2: When `div_load` is high at a clock edge, the divisor becomes `{div_hi, div_lo}`, with `div_hi` as bits 15..8 and `div_lo` as bits 7..0.
- R3: With `presc_en` at 0 and a divisor N from 1 to 65535, rising pulses of `tick` are N reference cycles apart. For N of 2 or more, each pulse is high for exactly one cycle.
- R4: With `presc_en` at 1 and a divisor N, pulses are 4*N reference cycles apart.
- R5: A divisor of 1 passes the step rate through. `tick` is high on every cycle when the prescaler is off, and on every fourth cycle when it is on.
- R6: While the latched divisor is zero, `tick` stays low.
- R7: A load restarts the counter. `tick` is low in the cycle after the load edge. With the prescaler off, the first pulse of the new divisor N becomes visible just after the (N+2)th edge, counting the load edge as the first.
- R8: A change of `presc_en` clears the prescaler phase. If `presc_en` goes from 0 to 1 at the load edge, the first pulse becomes visible 4*N edges after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| div_load | input | 1 | Strobe that latches both divisor bytes |
| presc_en | input | 1 | 1 selects the divide-by-four prescaler |
| tick | output | 1 | One-cycle 16x baud enable pulse |

## Verification
The bench sweeps small divisors with the prescaler off and on. It measures the delay from the load strobe to the first pulse and the spacing of the pulses that follow. A counter that is off by one in its reload comparison would shift every gap, and a reload that is not honoured would carry the old phase into the first new period.

The bench also loads 0x0100 against 0x0001 to catch swapped bytes, and loads 65535 to catch a counter that is too narrow. Divisor zero is checked for silence, including right after a divisor-1 stream. Switching the prescaler on at a load checks that its phase is cleared: a phase left over would show up as a short first period.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned PRE_RATIO_DEF = 4;
  localparam int unsigned DIV_W_DEF = 2 * BYTE_W_DEF;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int unsigned BYTE_W = baud_pkg::BYTE_W_DEF,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  input  logic             load,
  output logic [DIV_W-1:0] div_q,
  output logic             reload_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= load;
      if (load) div_q <= {hi, lo};
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned RATIO = baud_pkg::PRE_RATIO_DEF,
  localparam int unsigned PH_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  output logic sel_q,
  output logic step_en
);
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      phase <= '0;
    end else begin
      sel_q <= sel;
      if (sel != sel_q) phase <= '0;           // restart phase on mode change
      else if (sel_q) begin
        if (phase == PH_W'(RATIO - 1)) phase <= '0;
        else phase <= phase + PH_W'(1);
      end
    end
  end

  generate
    if (RATIO > 1) begin : g_div
      assign step_en = sel_q ? (phase == PH_W'(RATIO - 1)) : 1'b1;
    end else begin : g_pass
      assign step_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt #(
  parameter int unsigned DIV_W = baud_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [DIV_W-1:0] div,
  input  logic             reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (reload || div == '0) begin
        cnt <= '0;
      end else if (step_en) begin
        if (at_end) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top #(
  parameter int unsigned BYTE_W    = baud_pkg::BYTE_W_DEF,
  parameter int unsigned PRE_RATIO = baud_pkg::PRE_RATIO_DEF,
  localparam int unsigned DIV_W    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic              div_load,
  input  logic              presc_en,
  output logic              tick
);
  logic [DIV_W-1:0] div_q;
  logic             reload_q;
  logic             presc_q;
  logic             step_en;

  baud_div_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst(rst), .lo(div_lo), .hi(div_hi), .load(div_load),
    .div_q(div_q), .reload_q(reload_q)
  );

  baud_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk(clk), .rst(rst), .sel(presc_en), .sel_q(presc_q), .step_en(step_en)
  );

  baud_divcnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .step_en(step_en), .div(div_q),
    .reload(reload_q), .tick(tick)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int unsigned BYTE_W = baud_pkg::BYTE_W_DEF,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] div_lo,
  input logic [BYTE_W-1:0] div_hi,
  input logic              div_load,
  input logic              tick,
  input logic [DIV_W-1:0]  div_q,
  input logic              reload_q,
  input logic              presc_q
);
  // R2
  latch_capture_chk: assert property (@(posedge clk) disable iff (rst)
    div_load |=> div_q == {$past(div_hi), $past(div_lo)});

  // R6
  zero_div_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0 && !reload_q) |=> !tick);

  // R7
  reload_blank_chk: assert property (@(posedge clk) disable iff (rst)
    reload_q |=> !tick);

  // R4
  presc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (presc_q && tick) |=> !tick);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!tick && div_q == '0));
endmodule

bind baud_gen_top baud_gen_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .div_lo(div_lo), .div_hi(div_hi),
  .div_load(div_load), .tick(tick), .div_q(div_q),
  .reload_q(reload_q), .presc_q(presc_q)
);

// File: tb/tb_baud_gen_top.sv
module tb_baud_gen_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_lo = '0;
  logic [7:0] div_hi = '0;
  logic       div_load = 1'b0;
  logic       presc_en = 1'b0;
  logic       tick;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  localparam int CAP = 70000;

  always #2.5 clk = ~clk;

  baud_gen_top dut (
    .clk(clk), .rst(rst), .div_lo(div_lo), .div_hi(div_hi),
    .div_load(div_load), .presc_en(presc_en), .tick(tick)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a load; returns at the falling edge after the load edge.
  task automatic load(input int n, input logic p);
    @(negedge clk);
    div_lo = n[7:0];
    div_hi = n[15:8];
    presc_en = p;
    div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
  endtask

  task automatic latency(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < CAP);
  endtask

  task automatic period(output int n);
    int guard = 0;
    while (!tick && guard < CAP) begin
      @(negedge clk);
      guard++;
    end
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < CAP);
  endtask

  task automatic quiet(input int len, output int hits);
    hits = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tick) hits++;
    end
  endtask

  task automatic sweep_plain(input int n, input int reps);
    int v;
    load(n, 1'b0);
    latency(v);
    check("R7 latency", v, n + 1);
    for (int r = 0; r < reps; r++) begin
      period(v);
      check("R3 period", v, n);
    end
  endtask

  task automatic sweep_presc(input int n, input int reps);
    int v;
    load(1, 1'b0);
    repeat (3) @(negedge clk);
    load(n, 1'b1);
    latency(v);
    check("R8 prescaled latency", v, 4 * n);
    for (int r = 0; r < reps; r++) begin
      period(v);
      check("R4 prescaled period", v, 4 * n);
    end
  endtask

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: silent after reset with no divisor loaded
    quiet(50, v);
    check("R1 reset quiet", v, 0);

    // R3 / R7 sweep of small divisors, prescaler off
    for (int n = 1; n <= 12; n++) sweep_plain(n, 3);
    sweep_plain(1000, 2);

    // R5: divisor 1 keeps tick high every cycle
    load(1, 1'b0);
    @(negedge clk);
    quiet(20, v);
    check("R5 pass-through high count", v, 20);

    // R6: zero divisor right after a divisor-1 stream
    load(0, 1'b0);
    @(negedge clk);
    quiet(100, v);
    check("R6 zero divisor quiet", v, 0);

    // R2: byte order
    load(256, 1'b0);
    latency(v);
    check("R2 high byte latency", v, 257);
    load(1, 1'b0);
    latency(v);
    check("R2 low byte latency", v, 2);

    // R4 / R8 sweep with prescaler
    for (int n = 1; n <= 8; n++) sweep_presc(n, 2);
    sweep_presc(300, 2);

    // R5 with prescaler: divisor 1 pulses every fourth cycle
    load(1, 1'b0);
    repeat (2) @(negedge clk);
    load(1, 1'b1);
    repeat (8) @(negedge clk);
    quiet(40, v);
    check("R5 prescaled pass-through count", v, 10);

    // R3: full-width divisor
    load(65535, 1'b0);
    latency(v);
    check("R3 max divisor latency", v, 65536);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule